// File: doc/BRIEF.md
# Multicycle Register-Memory Datapath

This block is the data half of a 32-bit multicycle processor. It has one memory port, shared by instruction fetch and data access. It holds a program counter, an instruction latch, a memory data latch, two operand latches (A and B), an ALU result latch and a 32-entry register file. One ALU serves every step of every instruction. A separate controller sequences the block one clock at a time through these inputs:

- the memory address select;
- the two ALU operand selects;
- the ALU function code;
- the next-PC select;
- the write strobes.

The datapath returns the opcode, the function field and a zero flag to that controller.

Apart from loads, stores, branch-on-equal, jump and register-register add, subtract, and, or, the block supports an instruction that adds a register to a memory word. The memory address select has a third choice that sends latch B straight to memory as the address. The ALU second-operand select has a fifth choice that feeds the memory data latch into the ALU.

Memory is outside the block. It is word addressed: reads return within the cycle and writes take effect on the clock edge.

Top module: `mc_datapath`

## Requirements
- R1: While reset is high, PC, the instruction latch and the operand latches are zero. So with address select 00 the word address is 0, opcode and funct read 0, and with operand selects PC and B under subtract the zero flag is 1.
- R2: In a fetch step (address select 00, A-select 0, B-select 001, ALU code 0010, next-PC select 00, PC write and instruction write high), the word at the old PC is latched as the instruction and PC advances by 4.
- R3: In every cycle, the ALU result latch is loaded. In a decode step (B-select 011, ALU code 0010), that latch receives PC plus the sign-extended immediate IR[15:0] shifted left by two, which a later branch uses as its target.
- R4: ALU codes 0010 add, 0110 subtract, 0000 and, 0001 or. The zero output is 1 exactly when the ALU result is all zeros.
- R5: Loads and stores form the address as register rs (IR[25:21]) plus the sign-extended immediate (B-select 010) and access memory with address select 01. A load writes the memory data latch to register rt (IR[20:16]) with destination select 0 and write-back select 1. A store drives latch B (register rt) as write data.
- R6: With conditional PC write high, unconditional PC write low and next-PC select 01, PC loads the ALU result latch only when the zero output is 1; otherwise PC holds.
- R7: Next-PC select 10 with PC write loads PC with {PC[31:28], IR[25:0], 00}.
- R8: Register 0 always reads as zero; writes to it are discarded.
- R9: Address select 10 drives latch B (register rt) as the memory address, and B-select 100 feeds the memory data latch to the ALU. Together, register rs plus Mem[rt] can be written to register rd (IR[15:11], destination select 1, write-back select 0).
- R10: opcode shows IR[31:26] and funct shows IR[5:0] of the latched instruction.
- R11: The memory word address is bits [31:2] of the selected byte address; the memory data latch loads the memory read data every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_sel | input | 2 | Memory address source: 00 PC, 01 ALU result latch, 10 latch B |
| a_sel | input | 1 | ALU first operand: 0 PC, 1 latch A |
| b_sel | input | 3 | ALU second operand: 000 B, 001 constant 4, 010 immediate, 011 immediate shifted by 2, 100 memory data latch |
| alu_ctl | input | 4 | ALU function code |
| pc_src | input | 2 | Next PC: 00 ALU output, 01 ALU result latch, 10 jump target |
| pc_wr | input | 1 | Unconditional PC write |
| pc_wr_cond | input | 1 | PC write gated by the zero flag |
| ir_wr | input | 1 | Instruction latch write |
| reg_wr | input | 1 | Register file write |
| dst_sel | input | 1 | Write register: 0 rt, 1 rd |
| wb_sel | input | 1 | Write data: 0 ALU result latch, 1 memory data latch |
| mem_rd | input | 1 | Memory read request from controller |
| mem_wr | input | 1 | Memory write request from controller |
| mem_addr | output | 30 | Memory word address |
| mem_wdata | output | 32 | Memory write data (latch B) |
| mem_re | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_rdata | input | 32 | Memory read data |
| opcode | output | 6 | Instruction bits [31:26] |
| funct | output | 6 | Instruction bits [5:0] |
| zero | output | 1 | ALU result is zero |

## Verification
Two things can fall in one cycle, and the bench provokes both.

The first is the fetch step. The memory is read at the old PC while the same edge moves PC on by 4. Every fetch checks the word address against the bench's expected PC before the edge, and checks the latched opcode and funct after it.

The second is the branch step. The ALU subtract produces the zero flag, and in the same cycle that flag decides whether PC loads the decode-time target. The bench sweeps pairs of equal and unequal operands. It judges each branch by the zero output within the cycle and by the address of the next fetch. Register-memory add, loads with a negative offset and writes to register 0 are checked through words that later stores leave in memory.

// File: rtl/mc_pkg.sv
package mc_pkg;

    localparam int XLEN    = 32;
    localparam int REG_CNT = 32;
    localparam int RIDX_W  = $clog2(REG_CNT);
    localparam int IMM_W   = 16;
    localparam int OPC_W   = 6;
    localparam int JIDX_W  = 26;
    localparam int BYTE_SH = 2;

    typedef enum logic [1:0] {
        ADDR_PC     = 2'b00,
        ADDR_ALUOUT = 2'b01,
        ADDR_REGB   = 2'b10
    } addr_sel_e;

    typedef enum logic [2:0] {
        OPB_REGB   = 3'b000,
        OPB_FOUR   = 3'b001,
        OPB_IMM    = 3'b010,
        OPB_IMM_SH = 3'b011,
        OPB_MDR    = 3'b100
    } opb_sel_e;

    typedef enum logic [1:0] {
        PCN_ALU    = 2'b00,
        PCN_ALUOUT = 2'b01,
        PCN_JUMP   = 2'b10
    } pcn_sel_e;

    typedef enum logic [3:0] {
        ALU_AND = 4'b0000,
        ALU_OR  = 4'b0001,
        ALU_ADD = 4'b0010,
        ALU_SUB = 4'b0110
    } alu_op_e;

    // Raw latches that feed the routing logic
    typedef struct packed {
        logic [XLEN-1:0] pc;
        logic [XLEN-1:0] ir;
        logic [XLEN-1:0] mdr;
        logic [XLEN-1:0] a;
        logic [XLEN-1:0] b;
        logic [XLEN-1:0] aluout;
    } dp_state_t;

    function automatic logic [XLEN-1:0] sext_imm(input logic [IMM_W-1:0] v);
        return {{(XLEN-IMM_W){v[IMM_W-1]}}, v};
    endfunction

    function automatic logic [XLEN-1:0] alu_eval(input alu_op_e op,
                                                 input logic [XLEN-1:0] x,
                                                 input logic [XLEN-1:0] y);
        case (op)
            ALU_AND: return x & y;
            ALU_OR:  return x | y;
            ALU_ADD: return x + y;
            ALU_SUB: return x - y;
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/mc_alu.sv
module mc_alu
    import mc_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  logic [3:0]   ctl,
    output logic [W-1:0] res,
    output logic         is_zero
);
    always_comb begin
        res     = alu_eval(alu_op_e'(ctl), opa, opb);
        is_zero = (res == '0);
    end
endmodule

// File: rtl/mc_regfile.sv
module mc_regfile
    import mc_pkg::*;
#(
    parameter int W    = XLEN,
    parameter int NREG = REG_CNT,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] ra1,
    input  logic [AW-1:0] ra2,
    output logic [W-1:0]  rd1,
    output logic [W-1:0]  rd2,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd
);
    logic [W-1:0] slots [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) slots[i] <= '0;
        end else if (we && wa != '0) begin
            slots[wa] <= wd;
        end
    end

    always_comb begin
        rd1 = (ra1 == '0) ? '0 : slots[ra1];
        rd2 = (ra2 == '0) ? '0 : slots[ra2];
    end
endmodule

// File: rtl/mc_route.sv
module mc_route
    import mc_pkg::*;
#(
    parameter int W  = XLEN,
    localparam int MW = W - BYTE_SH
) (
    input  dp_state_t     st,
    input  logic [1:0]    addr_sel,
    input  logic          a_sel,
    input  logic [2:0]    b_sel,
    input  logic [1:0]    pc_src,
    input  logic [W-1:0]  alu_res,
    output logic [MW-1:0] word_addr,
    output logic [W-1:0]  opa,
    output logic [W-1:0]  opb,
    output logic [W-1:0]  pc_next
);
    logic [W-1:0] imm_x;

    always_comb begin
        imm_x = sext_imm(st.ir[IMM_W-1:0]);

        case (addr_sel_e'(addr_sel))
            ADDR_ALUOUT: word_addr = st.aluout[W-1:BYTE_SH];
            ADDR_REGB:   word_addr = st.b[W-1:BYTE_SH];
            default:     word_addr = st.pc[W-1:BYTE_SH];
        endcase

        opa = a_sel ? st.a : st.pc;

        case (opb_sel_e'(b_sel))
            OPB_FOUR:   opb = W'(4);
            OPB_IMM:    opb = imm_x;
            OPB_IMM_SH: opb = imm_x << BYTE_SH;
            OPB_MDR:    opb = st.mdr;
            default:    opb = st.b;
        endcase

        case (pcn_sel_e'(pc_src))
            PCN_ALUOUT: pc_next = st.aluout;
            PCN_JUMP:   pc_next = {st.pc[W-1:JIDX_W+BYTE_SH], st.ir[JIDX_W-1:0], 2'b00};
            default:    pc_next = alu_res;
        endcase
    end
endmodule

// File: rtl/mc_datapath.sv
module mc_datapath
    import mc_pkg::*;
#(
    parameter int W    = XLEN,
    parameter int NREG = REG_CNT,
    localparam int AW  = $clog2(NREG),
    localparam int MW  = W - BYTE_SH
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    addr_sel,
    input  logic          a_sel,
    input  logic [2:0]    b_sel,
    input  logic [3:0]    alu_ctl,
    input  logic [1:0]    pc_src,
    input  logic          pc_wr,
    input  logic          pc_wr_cond,
    input  logic          ir_wr,
    input  logic          reg_wr,
    input  logic          dst_sel,
    input  logic          wb_sel,
    input  logic          mem_rd,
    input  logic          mem_wr,
    output logic [MW-1:0] mem_addr,
    output logic [W-1:0]  mem_wdata,
    output logic          mem_re,
    output logic          mem_we,
    input  logic [W-1:0]  mem_rdata,
    output logic [5:0]    opcode,
    output logic [5:0]    funct,
    output logic          zero
);
    logic [W-1:0] pc_q, ir_q, mdr_q, a_q, b_q, aluout_q;
    logic [W-1:0] rs_val, rt_val, opa, opb, alu_res, pc_next, wb_data;
    logic [AW-1:0] wb_idx;
    dp_state_t st;

    assign st = '{pc: pc_q, ir: ir_q, mdr: mdr_q, a: a_q, b: b_q, aluout: aluout_q};

    mc_route #(.W(W)) u_route (
        .st       (st),
        .addr_sel (addr_sel),
        .a_sel    (a_sel),
        .b_sel    (b_sel),
        .pc_src   (pc_src),
        .alu_res  (alu_res),
        .word_addr(mem_addr),
        .opa      (opa),
        .opb      (opb),
        .pc_next  (pc_next)
    );

    mc_alu #(.W(W)) u_alu (
        .opa    (opa),
        .opb    (opb),
        .ctl    (alu_ctl),
        .res    (alu_res),
        .is_zero(zero)
    );

    always_comb begin
        wb_idx  = dst_sel ? ir_q[15:11] : ir_q[20:16];
        wb_data = wb_sel ? mdr_q : aluout_q;
    end

    mc_regfile #(.W(W), .NREG(NREG)) u_rf (
        .clk(clk),
        .rst(rst),
        .ra1(ir_q[25:21]),
        .ra2(ir_q[20:16]),
        .rd1(rs_val),
        .rd2(rt_val),
        .we (reg_wr),
        .wa (wb_idx),
        .wd (wb_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q     <= '0;
            ir_q     <= '0;
            mdr_q    <= '0;
            a_q      <= '0;
            b_q      <= '0;
            aluout_q <= '0;
        end else begin
            if (pc_wr || (pc_wr_cond && zero)) pc_q <= pc_next;
            if (ir_wr) ir_q <= mem_rdata;
            mdr_q    <= mem_rdata;
            a_q      <= rs_val;
            b_q      <= rt_val;
            aluout_q <= alu_res;
        end
    end

    assign mem_wdata = b_q;
    assign mem_re    = mem_rd;
    assign mem_we    = mem_wr;
    assign opcode    = ir_q[W-1:W-OPC_W];
    assign funct     = ir_q[5:0];
endmodule

// File: rtl/mc_datapath_chk.sv
module mc_datapath_chk
    import mc_pkg::*;
#(
    parameter int W = XLEN
) (
    input logic              clk,
    input logic              rst,
    input logic              pc_wr,
    input logic              pc_wr_cond,
    input logic [1:0]        pc_src,
    input logic              zero,
    input logic              ir_wr,
    input logic [W-1:0]      pc_q,
    input logic [JIDX_W-1:0] jfield,
    input logic [W-1:0]      a_q,
    input logic [W-1:0]      aluout_q
);
    // R6: without any enabled write, PC holds
    assert_pc_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!pc_wr && !(pc_wr_cond && zero)) |=> $stable(pc_q));

    // R6: taken branch loads the latched target
    assert_branch_target_R6: assert property (@(posedge clk) disable iff (rst)
        (pc_wr_cond && zero && !pc_wr && pc_src == 2'b01) |=> pc_q == $past(aluout_q));

    // R7: jump target composition
    assert_jump_R7: assert property (@(posedge clk) disable iff (rst)
        (pc_wr && pc_src == 2'b10) |=>
        pc_q == {$past(pc_q[W-1:JIDX_W+BYTE_SH]), $past(jfield), 2'b00});

    // R2: instruction latch holds without its strobe
    assert_ir_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !ir_wr |=> $stable(jfield));

    // R8: a zero rs index yields a zero A operand
    assert_reg0_R8: assert property (@(posedge clk) disable iff (rst)
        (jfield[25:21] == 5'd0) |=> a_q == '0);
endmodule

bind mc_datapath mc_datapath_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .pc_wr     (pc_wr),
    .pc_wr_cond(pc_wr_cond),
    .pc_src    (pc_src),
    .zero      (zero),
    .ir_wr     (ir_wr),
    .pc_q      (pc_q),
    .jfield    (ir_q[JIDX_W-1:0]),
    .a_q       (a_q),
    .aluout_q  (aluout_q)
);

// File: tb/mc_datapath_test.sv
module mc_datapath_test;
    import mc_pkg::*;

    localparam logic [5:0] OP_LW = 6'h23, OP_SW = 6'h2b, OP_BEQ = 6'h04, OP_J = 6'h02;
    localparam logic [5:0] FN_ADD = 6'h20, FN_SUB = 6'h22, FN_AND = 6'h24, FN_OR = 6'h25, FN_ADDM = 6'h38;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst;
    logic [1:0]  addr_sel, pc_src;
    logic        a_sel;
    logic [2:0]  b_sel;
    logic [3:0]  alu_ctl;
    logic        pc_wr, pc_wr_cond, ir_wr, reg_wr, dst_sel, wb_sel, mem_rd, mem_wr;
    logic [29:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata;
    logic        mem_re, mem_we, zero;
    logic [5:0]  opcode, funct;

    mc_datapath uut (
        .clk(clk), .rst(rst), .addr_sel(addr_sel), .a_sel(a_sel), .b_sel(b_sel),
        .alu_ctl(alu_ctl), .pc_src(pc_src), .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond),
        .ir_wr(ir_wr), .reg_wr(reg_wr), .dst_sel(dst_sel), .wb_sel(wb_sel),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_re(mem_re), .mem_we(mem_we), .mem_rdata(mem_rdata),
        .opcode(opcode), .funct(funct), .zero(zero)
    );

    logic [31:0] mem [0:127];
    assign mem_rdata = mem[mem_addr[6:0]];
    always @(posedge clk) if (mem_we) mem[mem_addr[6:0]] <= mem_wdata;

    int n_cmp = 0;
    int n_bad = 0;
    logic [31:0] exp_pc;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [1:0] as, input logic asrc, input logic [2:0] bs,
                         input logic [3:0] ac, input logic [1:0] ps, input logic pw,
                         input logic pwc, input logic irw, input logic rw, input logic rd,
                         input logic wb, input logic mr, input logic mw);
        addr_sel = as; a_sel = asrc; b_sel = bs; alu_ctl = ac; pc_src = ps;
        pc_wr = pw; pc_wr_cond = pwc; ir_wr = irw; reg_wr = rw; dst_sel = rd;
        wb_sel = wb; mem_rd = mr; mem_wr = mw;
    endtask

    function automatic logic [31:0] rtype(input logic [4:0] rs, input logic [4:0] rt,
                                          input logic [4:0] rd, input logic [5:0] fn);
        return {6'd0, rs, rt, rd, 5'd0, fn};
    endfunction

    function automatic logic [31:0] itype(input logic [5:0] op, input logic [4:0] rs,
                                          input logic [4:0] rt, input logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction

    function automatic logic [3:0] alu_code(input logic [5:0] fn);
        case (fn)
            FN_SUB:  return 4'b0110;
            FN_AND:  return 4'b0000;
            FN_OR:   return 4'b0001;
            default: return 4'b0010;
        endcase
    endfunction

    // Bench acts as the controller: one call per instruction
    task automatic run(input logic [31:0] ins, input logic taken);
        // fetch
        drive(2'b00, 1'b0, 3'b001, 4'b0010, 2'b00, 1, 0, 1, 0, 0, 0, 1, 0);
        #1;
        chk("R11/R2 fetch word address", {2'b00, mem_addr}, {2'b00, exp_pc[31:2]});
        mem[exp_pc[8:2]] = ins;
        @(negedge clk);
        exp_pc = exp_pc + 32'd4;
        chk("R10 opcode", {26'd0, opcode}, {26'd0, ins[31:26]});
        chk("R10 funct", {26'd0, funct}, {26'd0, ins[5:0]});
        // decode
        drive(2'b00, 1'b0, 3'b011, 4'b0010, 2'b00, 0, 0, 0, 0, 0, 0, 0, 0);
        @(negedge clk);
        case (ins[31:26])
            6'd0: begin
                if (ins[5:0] == FN_ADDM) begin
                    drive(2'b10, 1'b0, 3'b000, 4'b0010, 2'b00, 0, 0, 0, 0, 0, 0, 1, 0);
                    @(negedge clk);
                    drive(2'b00, 1'b1, 3'b100, 4'b0010, 2'b00, 0, 0, 0, 0, 0, 0, 0, 0);
                    @(negedge clk);
                end else begin
                    drive(2'b00, 1'b1, 3'b000, alu_code(ins[5:0]), 2'b00, 0, 0, 0, 0, 0, 0, 0, 0);
                    @(negedge clk);
                end
                drive(2'b00, 1'b0, 3'b000, 4'b0010, 2'b00, 0, 0, 0, 1, 1, 0, 0, 0);
                @(negedge clk);
            end
            OP_LW: begin
                drive(2'b00, 1'b1, 3'b010, 4'b0010, 2'b00, 0, 0, 0, 0, 0, 0, 0, 0);
                @(negedge clk);
                drive(2'b01, 1'b0, 3'b000, 4'b0010, 2'b00, 0, 0, 0, 0, 0, 0, 1, 0);
                @(negedge clk);
                drive(2'b00, 1'b0, 3'b000, 4'b0010, 2'b00, 0, 0, 0, 1, 0, 1, 0, 0);
                @(negedge clk);
            end
            OP_SW: begin
                drive(2'b00, 1'b1, 3'b010, 4'b0010, 2'b00, 0, 0, 0, 0, 0, 0, 0, 0);
                @(negedge clk);
                drive(2'b01, 1'b0, 3'b000, 4'b0010, 2'b00, 0, 0, 0, 0, 0, 0, 0, 1);
                @(negedge clk);
            end
            OP_BEQ: begin
                drive(2'b00, 1'b1, 3'b000, 4'b0110, 2'b01, 0, 1, 0, 0, 0, 0, 0, 0);
                #1;
                chk("R4/R6 zero flag on compare", {31'd0, zero}, {31'd0, taken});
                @(negedge clk);
                if (taken) exp_pc = exp_pc + {{14{ins[15]}}, ins[15:0], 2'b00};
            end
            OP_J: begin
                drive(2'b00, 1'b0, 3'b000, 4'b0010, 2'b10, 1, 0, 0, 0, 0, 0, 0, 0);
                @(negedge clk);
                exp_pc = {exp_pc[31:28], ins[25:0], 2'b00};
            end
            default: ;
        endcase
    endtask

    logic [31:0] vals [6];
    bit done = 0;

    initial begin
        vals[0] = 32'h0;        vals[1] = 32'h1;        vals[2] = 32'h7fffffff;
        vals[3] = 32'h80000000; vals[4] = 32'hffffffff; vals[5] = 32'h5;
        for (int i = 0; i < 128; i++) mem[i] = 32'h0;
        rst = 1'b1;
        drive(2'b00, 1'b0, 3'b000, 4'b0110, 2'b00, 0, 0, 0, 0, 0, 0, 0, 0);
        repeat (3) @(negedge clk);
        // R1: reset state visible at the ports
        chk("R1 reset word address", {2'b00, mem_addr}, 32'd0);
        chk("R1 reset opcode", {26'd0, opcode}, 32'd0);
        chk("R1 reset funct", {26'd0, funct}, 32'd0);
        chk("R1 reset zero flag", {31'd0, zero}, 32'd1);
        rst = 1'b0;
        exp_pc = 32'd0;

        for (int i = 0; i < 6; i++) begin
            for (int j = 0; j < 6; j++) begin
                logic [31:0] x, y;
                logic [25:0] tgt;
                x = vals[i];
                y = vals[j];
                tgt = 26'((((i * 6) + j) % 4) * 2);
                mem[64] = x; mem[65] = y; mem[66] = 32'd260;
                for (int k = 80; k < 87; k++) mem[k] = 32'hdeadbeef;

                run(itype(OP_LW, 5'd0, 5'd1, 16'd256), 1'b0);
                run(itype(OP_LW, 5'd0, 5'd2, 16'd260), 1'b0);
                run(itype(OP_LW, 5'd0, 5'd5, 16'd264), 1'b0);
                run(rtype(5'd1, 5'd2, 5'd3, FN_ADD), 1'b0);
                run(itype(OP_SW, 5'd0, 5'd3, 16'd320), 1'b0);
                run(rtype(5'd1, 5'd2, 5'd3, FN_SUB), 1'b0);
                run(itype(OP_SW, 5'd0, 5'd3, 16'd324), 1'b0);
                run(rtype(5'd1, 5'd2, 5'd3, FN_AND), 1'b0);
                run(itype(OP_SW, 5'd0, 5'd3, 16'd328), 1'b0);
                run(rtype(5'd1, 5'd2, 5'd3, FN_OR), 1'b0);
                run(itype(OP_SW, 5'd0, 5'd3, 16'd332), 1'b0);
                run(rtype(5'd1, 5'd5, 5'd4, FN_ADDM), 1'b0);
                run(itype(OP_SW, 5'd0, 5'd4, 16'd336), 1'b0);
                run(rtype(5'd1, 5'd2, 5'd0, FN_ADD), 1'b0);
                run(itype(OP_SW, 5'd0, 5'd0, 16'd340), 1'b0);
                run(itype(OP_LW, 5'd5, 5'd6, 16'hfffc), 1'b0);
                run(itype(OP_SW, 5'd0, 5'd6, 16'd344), 1'b0);

                chk("R4 add result", mem[80], x + y);
                chk("R4 sub result", mem[81], x - y);
                chk("R4 and result", mem[82], x & y);
                chk("R4 or result", mem[83], x | y);
                chk("R9 register plus memory add", mem[84], x + y);
                chk("R8 register 0 write discarded", mem[85], 32'd0);
                chk("R5 load with negative offset", mem[86], x);

                // R3/R6: branch target from decode, taken only on equality
                run(itype(OP_BEQ, 5'd1, 5'd2, 16'd1), x == y);
                // R7: jump; next fetch address checks the target
                run({OP_J, tgt}, 1'b0);
            end
        end
        run(rtype(5'd0, 5'd0, 5'd7, FN_ADD), 1'b0);

        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule